// File: doc/BRIEF.md
# I2C Slave Engine with Clock Stretching

This block is the slave side of a two-wire serial bus controller. It follows the bus through a two-flop synchroniser, spots START and STOP, and compares each address byte with a programmable 7-bit device address. It also recognises the all-zero general call. When addressed it receives or sends data words, acknowledges what it receives, and raises an interrupt at the end of every event. At that point it holds SCL low, so the bus waits until the host has dealt with the event.

The host sees three small registers: a data buffer, a control/status register and the own-address register. Reading or writing the buffer, or writing a 1 to the pending bit, ends the stall. SCL is then released a fixed number of system clocks later. A companion master slice can report lost arbitration. The engine then drops to slave operation, completes the word in flight, and interrupts so the host can decide how to continue.

Top module: `i2c_slave_stretch`

## Requirements
- R1: After a START, an address byte whose upper seven bits equal the own address (register 2, bits 6:0) is acknowledged: SDA is driven low during the ninth clock, and the addressed-as-slave flag (status bit 2) reads 1.
- R2: An address byte of 0x00 is taken as a general call. It is acknowledged, status bit 1 reads 1 and status bit 2 stays 0.
- R3: Any other address byte is not acknowledged. SDA stays released, and neither that byte nor the data words after it raise the interrupt.
- R4: At the falling edge that ends the ninth clock of a serviced event, `irq` goes high and status bit 0 (pending, active low) reads 0. SCL is held low for as long as `irq` is high. After reset the status register reads 0x01 and nothing drives the bus.
- R5: A host read or write of the data buffer (register 0), or a write to control (register 1) with bit 0 set, drops `irq` on the next clock. SCL is released exactly TLOW clocks after the access.
- R6: Data words received while addressed are acknowledged. Each raises the interrupt, and reading register 0 returns the word.
- R7: When the direction bit of a matched address is 1, status bit 3 (transmitting) reads 1. The engine then sends the buffer contents MSB first after the host writes them, and each word the master acknowledges raises the interrupt.
- R8: As transmitter, a NACK from the master ends the transfer. SDA is released, SCL is not stretched and no interrupt follows.
- R9: Control bits 3:1 set the data word length in bits, with 0 meaning 8. A word of N bits carries the low N bits of the buffer, and received words read back zero-extended.
- R10: An arbitration-lost pulse sets status bit 4 and clears the master bit (control/status bit 5). The current word is completed, and the interrupt is raised at its end even when the engine is not addressed. A control write clears status bit 4.
- R11: A STOP clears status bits 1, 2 and 3, and the engine returns to watching for an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| arb_lost | input | 1 | One-cycle pulse from the master slice on lost arbitration |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register select: 0 buffer, 1 control/status, 2 own address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Interrupt, high while an event waits for service |

## Verification
The bench counts the clocks between the host access and the moment SCL is let go. An off-by-one release counter, or a release triggered on the wrong access, therefore shows up at once. Word lengths other than eight are exercised in both directions, because a design that ignored the length field would shift the wrong number of bits and return masked values that differ. A transmit that ends in a NACK is checked for a missing stretch, since a design that kept interrupting would hang the bus waiting for service. An arbitration-lost pulse is injected during a word addressed to another device: a design that only interrupted on an address match would never stall there.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_HOLD,
    ST_TX,
    ST_TXACK,
    ST_DONE
  } i2cs_state_t;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_OWN  = 2'd2;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cs_release_timer.sv
module i2cs_release_timer #(
  parameter int TLOW = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(TLOW + 1);
  logic          run;
  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(TLOW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (done) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch
  import i2cs_pkg::*;
#(
  parameter int         TLOW        = 40,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] OWN_RST     = 7'h7F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       arb_lost,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic rel_req, rel_done;

  i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_release_timer #(.TLOW(TLOW)) u_rel (
    .clk(clk), .rst(rst), .start(rel_req), .done(rel_done)
  );

  i2cs_state_t st;
  logic [3:0]  cnt;
  logic        is_addr;
  logic [7:0]  shreg, rx_buf, tx_buf;
  logic [6:0]  own;
  logic [2:0]  bit_cfg;
  logic        mst, al, al_pend, trx, aas, ad0, lrb;

  logic [3:0] nbits, word_bits;
  logic [2:0] tx_idx, tx_first;
  logic       buf_touch, pin_set;

  assign nbits     = (bit_cfg == 3'd0) ? 4'd8 : {1'b0, bit_cfg};
  assign word_bits = is_addr ? 4'd8 : nbits;
  assign tx_first  = 3'(nbits - 4'd1);
  assign tx_idx    = 3'(nbits - 4'd1 - cnt);
  assign buf_touch = (host_wr | host_rd) && (host_addr == RA_DATA);
  assign pin_set   = host_wr && (host_addr == RA_CTRL) && host_wdata[0];
  assign rel_req   = (st == ST_HOLD) && irq && (buf_touch || pin_set);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  cnt <= '0;  is_addr <= 1'b0;  shreg <= '0;
      rx_buf <= '0;   tx_buf <= '0;  own <= OWN_RST;  bit_cfg <= '0;
      mst <= 1'b0;  al <= 1'b0;  al_pend <= 1'b0;  trx <= 1'b0;
      aas <= 1'b0;  ad0 <= 1'b0;  lrb <= 1'b0;  irq <= 1'b0;
      scl_oe <= 1'b0;  sda_oe <= 1'b0;  host_rdata <= '0;
    end else begin
      // host side
      if (host_wr) begin
        case (host_addr)
          RA_DATA: tx_buf <= host_wdata;
          RA_CTRL: begin
            bit_cfg <= host_wdata[3:1];
            mst     <= host_wdata[4];
            al      <= 1'b0;
          end
          RA_OWN:  own <= host_wdata[6:0];
          default: ;
        endcase
      end
      if (host_rd) begin
        case (host_addr)
          RA_DATA: host_rdata <= rx_buf;
          RA_CTRL: host_rdata <= {1'b0, lrb, mst, al, trx, aas, ad0, ~irq};
          RA_OWN:  host_rdata <= {1'b0, own};
          default: host_rdata <= '0;
        endcase
      end
      if (rel_req) irq <= 1'b0;
      if (arb_lost) begin
        al      <= 1'b1;
        mst     <= 1'b0;
        al_pend <= 1'b1;
      end

      // bus side
      if (stop_det && st != ST_HOLD) begin
        st <= ST_IDLE;  sda_oe <= 1'b0;
        aas <= 1'b0;  ad0 <= 1'b0;  trx <= 1'b0;
      end else if (start_det && st != ST_HOLD) begin
        st <= ST_RX;  is_addr <= 1'b1;  cnt <= '0;  shreg <= '0;
        sda_oe <= 1'b0;  aas <= 1'b0;  ad0 <= 1'b0;  trx <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == word_bits) begin
              st <= ST_ACK;
              if (is_addr) begin
                if (shreg == 8'h00) begin
                  ad0 <= 1'b1;  sda_oe <= 1'b1;
                end else if (shreg[7:1] == own) begin
                  aas <= 1'b1;  trx <= shreg[0];  sda_oe <= 1'b1;
                end
              end else begin
                rx_buf <= shreg;
                if (aas || ad0) sda_oe <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;  is_addr <= 1'b0;  cnt <= '0;  shreg <= '0;
              if (aas || ad0 || al_pend) begin
                st <= ST_HOLD;  scl_oe <= 1'b1;  irq <= 1'b1;  al_pend <= 1'b0;
              end else begin
                st <= ST_RX;
              end
            end
          end
          ST_HOLD: begin
            if (rel_done) begin
              scl_oe <= 1'b0;  cnt <= '0;  shreg <= '0;
              if (trx) begin
                st     <= ST_TX;
                sda_oe <= ~tx_buf[tx_first];
              end else begin
                st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == nbits) begin
                sda_oe <= 1'b0;  st <= ST_TXACK;
              end else begin
                sda_oe <= ~tx_buf[tx_idx];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              lrb <= sda_s;
            end else if (scl_fall) begin
              if (lrb) begin
                st <= ST_DONE;
              end else begin
                st <= ST_HOLD;  scl_oe <= 1'b1;  irq <= 1'b1;  al_pend <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int TLOW = 40
) (
  input logic clk,
  input logic rst,
  input logic irq,
  input logic scl_oe,
  input logic stop_det,
  input logic aas,
  input logic ad0,
  input logic trx,
  input logic arb_lost,
  input logic al,
  input logic mst
);
  logic [15:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst)         hold_cnt <= '0;
    else if (irq)    hold_cnt <= '0;
    else if (scl_oe) hold_cnt <= hold_cnt + 16'd1;
  end

  assert_irq_holds_scl_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> scl_oe);

  assert_stretch_with_irq_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> irq);

  assert_release_delay_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> hold_cnt == 16'(TLOW));

  assert_transmit_needs_match_R7: assert property (@(posedge clk) disable iff (rst)
    trx |-> aas);

  assert_arb_lost_flags_R10: assert property (@(posedge clk) disable iff (rst)
    arb_lost |=> (al && !mst));

  assert_stop_clears_R11: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!aas && !ad0 && !trx));
endmodule

bind i2c_slave_stretch i2cs_checker #(.TLOW(TLOW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .scl_oe(scl_oe), .stop_det(stop_det),
  .aas(aas), .ad0(ad0), .trx(trx), .arb_lost(arb_lost), .al(al), .mst(mst)
);

// File: tb/i2c_slave_stretch_bench.sv
module i2c_slave_stretch_bench;
  localparam int         TLOW = 40;
  localparam int         Q    = 10;
  localparam logic [6:0] OWN  = 7'h5C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, arb_lost = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0, host_rdata;
  logic irq;
  logic scl_bus, sda_bus;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign scl_bus = !(m_scl_low || scl_oe);
  assign sda_bus = !(m_sda_low || sda_oe);

  i2c_slave_stretch #(.TLOW(TLOW)) u_i2c_slave_stretch (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .arb_lost(arb_lost),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(input int n);
    return (n == 8) ? 8'hFF : 8'((1 << n) - 1);
  endfunction

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  // kind 0: pending bit write, 1: buffer read, 2: buffer write
  task automatic release_check(input int kind, input logic [2:0] bc,
                               input logic [7:0] wv, output logic [7:0] rv);
    rv = 8'd0;
    if (kind == 0)      host_write(2'd1, {4'b0, bc, 1'b1});
    else if (kind == 1) host_read(2'd0, rv);
    else                host_write(2'd0, wv);
    chk(irq == 1'b0, "R5 irq drop", int'(irq), 0);
    repeat (TLOW - 1) @(negedge clk);
    chk(scl_oe == 1'b1, "R5 still held", int'(scl_oe), 1);
    @(negedge clk);
    chk(scl_oe == 1'b0, "R5 released", int'(scl_oe), 0);
  endtask

  task automatic m_start();
    m_sda_low = 1'b1; waitq(); m_scl_low = 1'b1; waitq();
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; waitq(); m_scl_low = 1'b0;
    wait (scl_bus == 1'b1); waitq(); m_sda_low = 1'b0; waitq();
  endtask

  task automatic m_clk(input logic b, output logic r);
    m_sda_low = ~b; waitq(); m_scl_low = 1'b0;
    wait (scl_bus == 1'b1); waitq(); r = sda_bus;
    m_scl_low = 1'b1; waitq();
  endtask

  task automatic m_word(input logic [7:0] v, input int n, output logic ack);
    logic r;
    for (int i = n - 1; i >= 0; i--) m_clk(v[i], r);
    m_clk(1'b1, ack);
  endtask

  task automatic m_read(input int n, input logic nack, output logic [7:0] v);
    logic r;
    v = 8'd0;
    for (int i = 0; i < n; i++) begin
      m_clk(1'b1, r);
      v = {v[6:0], r};
    end
    m_clk(nack, r);
  endtask

  task automatic do_xfer(input logic [6:0] a, input logic rw, input int nw, input logic [2:0] bc);
    logic ack, is_own, is_gc;
    logic [7:0] st, v, got, dummy;
    int n;
    n      = (bc == 3'd0) ? 8 : int'(bc);
    is_own = (a == OWN);
    is_gc  = (a == 7'd0) && !rw;
    host_write(2'd1, {4'b0, bc, 1'b0});
    m_start();
    m_word({a, rw}, 8, ack);
    if (is_own || is_gc) begin
      chk(ack == 1'b0, is_own ? "R1 address ack" : "R2 general call ack", int'(ack), 0);
      chk(irq == 1'b1 && scl_oe == 1'b1, "R4 stretch on event", int'({irq, scl_oe}), 3);
      host_read(2'd1, st);
      chk((st & 8'hBF) == {4'b0, is_own & rw, is_own, is_gc, 1'b0},
          "R4 status after address", int'(st & 8'hBF), int'({4'b0, is_own & rw, is_own, is_gc, 1'b0}));
      if (!rw) release_check(0, bc, 8'd0, dummy);
    end else begin
      chk(ack == 1'b1 && irq == 1'b0, "R3 foreign address", int'({ack, irq}), 2);
    end
    for (int w = 0; w < nw; w++) begin
      v = 8'($urandom);
      if (is_own && rw) begin
        release_check(2, bc, v, dummy);
        m_read(n, (w == nw - 1), got);
        chk(got == (v & wmask(n)), "R7 R9 transmit data", int'(got), int'(v & wmask(n)));
        if (w != nw - 1) begin
          chk(irq == 1'b1, "R7 irq after acked word", int'(irq), 1);
        end else begin
          chk(irq == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R8 nack ends transfer",
              int'({irq, scl_oe, sda_oe}), 0);
        end
      end else if (is_own || is_gc) begin
        m_word(v & wmask(n), n, ack);
        chk(ack == 1'b0 && irq == 1'b1, "R6 data ack and irq", int'({ack, irq}), 1);
        release_check(1, bc, 8'd0, got);
        chk(got == (v & wmask(n)), "R6 R9 received data", int'(got), int'(v & wmask(n)));
      end else begin
        m_word(v & wmask(n), n, ack);
        chk(ack == 1'b1 && irq == 1'b0, "R3 foreign data ignored", int'({ack, irq}), 2);
      end
    end
    m_stop();
    host_read(2'd1, st);
    chk((st & 8'hBF) == 8'h01, "R11 stop clears flags", int'(st & 8'hBF), 1);
  endtask

  initial begin
    logic [7:0] rd, v, dummy;
    logic ack;
    logic [6:0] a;
    logic rw;
    int sel;
    rd = $urandom(32'd20240607);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R4 reset outputs",
        int'({irq, scl_oe, sda_oe}), 0);
    host_read(2'd1, rd);
    chk(rd == 8'h01, "R4 reset status", int'(rd), 1);
    host_write(2'd2, {1'b0, OWN});
    host_read(2'd2, rd);
    chk(rd == {1'b0, OWN}, "R1 own address", int'(rd), int'(OWN));

    do_xfer(OWN, 1'b0, 3, 3'd0);
    do_xfer(7'd0, 1'b0, 2, 3'd0);
    do_xfer(7'h11, 1'b0, 2, 3'd0);
    do_xfer(OWN, 1'b1, 3, 3'd0);
    do_xfer(OWN, 1'b0, 2, 3'd5);
    do_xfer(OWN, 1'b1, 2, 3'd3);

    // R10: arbitration lost during a word for another device
    host_write(2'd1, 8'h10);
    host_read(2'd1, rd);
    chk((rd & 8'hBF) == 8'h21, "R10 master bit set", int'(rd & 8'hBF), 8'h21);
    m_start();
    m_word({7'h22, 1'b0}, 8, ack);
    chk(ack == 1'b1 && irq == 1'b0, "R3 foreign before arb loss", int'({ack, irq}), 2);
    fork
      m_word(8'hA5, 8, ack);
      begin
        repeat (60) @(negedge clk);
        arb_lost = 1'b1;
        @(negedge clk);
        arb_lost = 1'b0;
      end
    join
    chk(irq == 1'b1 && scl_oe == 1'b1, "R10 irq after lost word", int'({irq, scl_oe}), 3);
    host_read(2'd1, rd);
    chk((rd & 8'hBF) == 8'h10, "R10 status al set mst clear", int'(rd & 8'hBF), 8'h10);
    release_check(0, 3'd0, 8'd0, dummy);
    m_stop();
    host_read(2'd1, rd);
    chk((rd & 8'hBF) == 8'h01, "R10 al cleared by control write", int'(rd & 8'hBF), 1);

    for (int it = 0; it < 16; it++) begin
      sel = $urandom % 4;
      rw  = 1'($urandom);
      if (sel == 0) a = OWN;
      else if (sel == 1) begin a = 7'd0; rw = 1'b0; end
      else begin
        a = 7'(1 + ($urandom % 126));
        if (a == OWN) a = a ^ 7'd1;
      end
      do_xfer(a, rw, 1 + ($urandom % 3), 3'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule